// File: doc/BRIEF.md
# Serial-Programmed LED Channel Driver Logic

This block is the digital control core of a multi-channel on/off LED sink driver. A host streams channel states one bit at a time on a serial data line and a serial clock into a shift register. A transfer input then copies the register into the channel latches. The channel enables drive open-drain sink switches, where 1 switches the LED on. A serial output taken from the far end of the register lets several drivers share one data stream. Bits for the far device go first, and each device keeps the last bits it received.

Two gating inputs force every channel off: a blanking input and a battery over-voltage flag. Neither of them touches the shift register or the latches, so the programmed pattern comes back as soon as both inputs are inactive. An under-voltage reset input clears the register and the latches. The serial clock is sampled in a system clock domain. A rising edge is found by comparing the sampled clock with its value one cycle earlier, so the logic is synchronous throughout.

Top module: `led_chain_driver`

## Requirements
- R1: The shift register advances exactly one stage for each rising edge of `sclk`. A high level held for several cycles and a falling edge cause no shift.
- R2: Channel 0 (bit 0 of `ch_en`) takes the most recently shifted bit. In a 10-bit frame the first bit lands on channel 9 (bit 9).
- R3: `sout` equals the register stage that feeds channel 9, and it changes only on a rising `sclk` edge.
- R4: While `xfer` is 0, `ch_en` keeps the latched pattern even while new bits are shifted.
- R5: While `xfer` is 1, the latch is transparent, and every shifted bit appears on `ch_en` in the same system cycle as the shift.
- R6: While `blank` is 1, `ch_en` is all zeros. When it returns to 0, the earlier latched pattern reappears.
- R7: While `ovp` is 1, `ch_en` is all zeros. When it clears, the latched pattern returns without reprogramming.
- R8: A low `rst_n` at a clock edge clears the register and the latches. After that, `sout` stays 0 until ten bits have been shifted in.
- R9: A 1 in a channel bit enables that sink, and a 0 disables it.
- R10: With two devices chained `sout` to `sin`, 20 shifted bits split so that the first ten land in the downstream device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all other inputs |
| rst_n | input | 1 | Under-voltage reset, active low, synchronous |
| sclk | input | 1 | Serial clock; rising edge shifts |
| sin | input | 1 | Serial data input |
| xfer | input | 1 | Transfer enable; 1 makes the latches transparent |
| blank | input | 1 | Active-high blanking of all channels |
| ovp | input | 1 | Active-high battery over-voltage flag |
| ch_en | output | NUM_CH | Channel sink enables, 1 = on |
| sout | output | 1 | Serial output for chaining |

## Verification
A wrong shift-register stage shows up on `sout` one system cycle after the rising edge that loads it. If `xfer` is high, it also shows on the matching bit of `ch_en` in that same cycle. A corrupted latch is hidden while blanking or over-voltage is active, but it appears on `ch_en` in the first cycle after both are released. The bench therefore compares `ch_en` both before and after every gating interval. A bit-order fault shows only as a mismatch between patterns, which is why the sweep covers every 10-bit value and a chained 20-bit split.

// File: rtl/led_drv_pkg.sv
// Package: shared constants and helpers for the LED channel driver.
// Assumes: nothing beyond IEEE 1800-2017.
package led_drv_pkg;
    localparam int unsigned DEF_NUM_CH = 10;

    // Reports whether any gating condition forces the outputs off.
    function automatic logic gate_active(input logic blank_i, input logic ovp_i);
        return blank_i | ovp_i;
    endfunction
endpackage

// File: rtl/led_sclk_edge.sv
// Module: finds rising edges of the serial clock in the system clock domain.
// Assumes: sclk is synchronous to clk and stays high or low for at least one clk cycle.
module led_sclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic rise
);
    logic sclk_q;

    // Keeps the serial clock level from the previous system cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    // Pulses for one cycle when the serial clock goes from low to high.
    always_comb rise = sclk & ~sclk_q;

    assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/led_shift_chain.sv
// Module: serial-in shift register. The newest bit enters stage 0 and the top stage drives sout.
// Assumes: shift is a one-cycle strobe derived from the serial clock.
module led_shift_chain #(
    parameter int unsigned N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift,
    input  logic         sin,
    output logic [N-1:0] q,
    output logic [N-1:0] q_next,
    output logic         sout
);
    localparam int unsigned TOP = N - 1;

    // Next register value: move one stage up and put the new bit into stage 0.
    always_comb q_next = shift ? {q[TOP-1:0], sin} : q;

    // Stores the register contents; reset clears every stage.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end

    // The serial output is the top stage.
    always_comb sout = q[TOP];

    assert_shift_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> (q[TOP:1] == $past(q[TOP-1:0])) && (q[0] == $past(sin)));
    assert_shift_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(q));
    assert_sout_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> sout == $past(q[TOP-1]));
endmodule

// File: rtl/led_xfer_latch.sv
// Module: channel latches modelled as enabled storage. They are transparent while xfer is high,
// so the register's next value passes through in the same cycle.
// Assumes: d is the shift register's next value.
module led_xfer_latch #(
    parameter int unsigned N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         xfer,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    // Copies d while xfer is high and holds otherwise; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (xfer) q <= d;
    end

    assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(q));
    assert_latch_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> q == $past(d));
endmodule

// File: rtl/led_out_gate.sv
// Module: per-channel output gating. Blanking or over-voltage forces every enable low.
// Assumes: the gating inputs are already synchronous to clk.
module led_out_gate #(
    parameter int unsigned N = 10
) (
    input  logic [N-1:0] latch,
    input  logic         blank,
    input  logic         ovp,
    output logic [N-1:0] ch_en
);
    import led_drv_pkg::*;

    logic kill;

    // Combines the two gating conditions.
    always_comb kill = gate_active(blank, ovp);

    for (genvar i = 0; i < int'(N); i++) begin : g_ch
        // One sink enable per channel.
        always_comb ch_en[i] = latch[i] & ~kill;
    end
endmodule

// File: rtl/led_chain_driver.sv
// Module: top of the LED channel driver. It connects edge detection, shift register,
// transfer latch and output gating.
// Assumes: clk runs faster than sclk, and every input is synchronous to clk.
module led_chain_driver #(
    parameter int unsigned NUM_CH = led_drv_pkg::DEF_NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sin,
    input  logic              xfer,
    input  logic              blank,
    input  logic              ovp,
    output logic [NUM_CH-1:0] ch_en,
    output logic              sout
);
    logic              rise;
    logic [NUM_CH-1:0] sr_q;
    logic [NUM_CH-1:0] sr_next;
    logic [NUM_CH-1:0] latch_q;

    led_sclk_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk),
        .rise  (rise)
    );

    led_shift_chain #(.N(NUM_CH)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .shift  (rise),
        .sin    (sin),
        .q      (sr_q),
        .q_next (sr_next),
        .sout   (sout)
    );

    led_xfer_latch #(.N(NUM_CH)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .xfer  (xfer),
        .d     (sr_next),
        .q     (latch_q)
    );

    led_out_gate #(.N(NUM_CH)) u_gate (
        .latch (latch_q),
        .blank (blank),
        .ovp   (ovp),
        .ch_en (ch_en)
    );

    assert_gate_keeps_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (blank || ovp) && !xfer |=> $stable(latch_q));
    assert_reset_clears_R8: assert property (@(posedge clk)
        !rst_n |=> (ch_en == '0) && (sout == 1'b0));
    assert_sr_sout_link_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(sout));
endmodule

// File: tb/led_chain_driver_tb.sv
// Bench: two chained drivers. It sweeps every 10-bit pattern, a chained 20-bit split,
// the gating inputs and reset.
module led_chain_driver_tb_top;
    localparam int N = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b0;
    logic         sin = 1'b0;
    logic         xfer = 1'b0;
    logic         blank = 1'b0;
    logic         ovp = 1'b0;
    logic [N-1:0] ch_up;
    logic [N-1:0] ch_dn;
    logic         sout_up;
    logic         sout_dn;
    int           checks = 0;
    int           fails = 0;
    bit           done = 0;

    always #2 clk = ~clk;

    led_chain_driver #(.NUM_CH(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sin(sin), .xfer(xfer),
        .blank(blank), .ovp(ovp), .ch_en(ch_up), .sout(sout_up));

    led_chain_driver #(.NUM_CH(N)) dut_dn_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sin(sout_up), .xfer(xfer),
        .blank(blank), .ovp(ovp), .ch_en(ch_dn), .sout(sout_dn));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One serial bit: raise sclk with data at a negedge, lower it one cycle later.
    task automatic shift_bit(input logic b);
        @(negedge clk); sin = b; sclk = 1'b1;
        @(negedge clk); sclk = 1'b0;
    endtask

    task automatic pulse_xfer;
        @(negedge clk); xfer = 1'b1;
        @(negedge clk); xfer = 1'b0;
    endtask

    initial begin
        logic [N-1:0] prev;
        logic [19:0]  w;
        logic [N-1:0] run;
        repeat (3) @(negedge clk);
        chk("R8 reset ch_en", 32'(ch_up), 0);
        chk("R8 reset sout", 32'(sout_up), 0);
        rst_n = 1'b1;

        // R8: sout stays 0 until the tenth one arrives
        for (int k = 1; k <= N; k++) begin
            shift_bit(1'b1);
            chk("R8 sout zero fill", 32'(sout_up), (k == N) ? 1 : 0);
        end

        // R1: held-high and falling sclk cause no shift
        shift_bit(1'b0);
        @(negedge clk); sclk = 1'b1; sin = 1'b0;
        repeat (3) @(negedge clk);
        sclk = 1'b0; sin = 1'b1;
        repeat (2) @(negedge clk);
        pulse_xfer();
        chk("R1 one shift per rising edge", 32'(ch_up), 32'h3FC);

        // R2, R4, R9: exhaustive pattern sweep, first bit to channel 9
        prev = ch_up;
        for (int p = 0; p < (1 << N); p++) begin
            for (int b = N - 1; b >= 0; b--) shift_bit(p[b]);
            chk("R4 hold while xfer low", 32'(ch_up), 32'(prev));
            chk("R3 sout is channel 9 source", 32'(sout_up), 32'(p[N-1]));
            pulse_xfer();
            chk("R2 R9 pattern on channels", 32'(ch_up), p);
            prev = ch_up;
        end

        // R10: chained 20-bit split
        for (int i = 0; i < 64; i++) begin
            w = 20'((i * 40503 + 12345) & 20'hFFFFF);
            for (int b = 19; b >= 0; b--) shift_bit(w[b]);
            pulse_xfer();
            chk("R10 downstream gets first ten", 32'(ch_dn), 32'(w[19:10]));
            chk("R10 upstream gets last ten", 32'(ch_up), 32'(w[9:0]));
            chk("R10 upstream sout", 32'(sout_up), 32'(w[9]));
        end

        // R5: transparent latch while xfer high
        @(negedge clk); xfer = 1'b1;
        run = ch_up;
        for (int k = 0; k < N; k++) begin
            logic bb;
            bb = logic'(k % 3 == 0);
            @(negedge clk); sin = bb; sclk = 1'b1;
            @(negedge clk); sclk = 1'b0;
            run = {run[N-2:0], bb};
            chk("R5 transparent update", 32'(ch_up), 32'(run));
        end
        @(negedge clk); xfer = 1'b0;

        // R6: blank forces off, shifting meanwhile, pattern restored
        @(negedge clk); blank = 1'b1;
        @(negedge clk);
        chk("R6 blank off", 32'(ch_up), 0);
        for (int k = 0; k < 4; k++) shift_bit(1'b1);
        chk("R6 blank still off", 32'(ch_up), 0);
        @(negedge clk); blank = 1'b0;
        @(negedge clk);
        chk("R6 restore after blank", 32'(ch_up), 32'(run));

        // R7: over-voltage forces off and restores
        @(negedge clk); ovp = 1'b1;
        @(negedge clk);
        chk("R7 ovp off", 32'(ch_up), 0);
        chk("R7 ovp off downstream", 32'(ch_dn), 0);
        @(negedge clk); ovp = 1'b0;
        @(negedge clk);
        chk("R7 restore after ovp", 32'(ch_up), 32'(run));

        // R8: reset mid-run clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R8 mid reset ch_en", 32'(ch_up), 0);
        chk("R8 mid reset sout", 32'(sout_up), 0);
        pulse_xfer();
        chk("R8 register cleared", 32'(ch_up), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule